// File: doc/BRIEF.md
# Oscillator and PLL control unit

This block is the register-level control for the clock sources of a chip. It holds run requests for three sources: an internal oscillator, an external oscillator and a PLL. For each source it keeps a ready flag. The flag follows its run request after a settle delay, both when the source is turned on and when it is turned off. Real oscillators are not modelled; the delays stand in for their start-up and shut-down times.

The block also holds a system clock selector. Software writes a requested source code. The active code, which drives `sel_src_o`, moves to the requested code only once that source reports ready. Software polls the active field of the switch register until it reads back the code it asked for. Two further fields are plain storage for downstream logic: an internal oscillator divider and a PLL reference selector.

Access is through a word-addressed port with a write strobe and a combinational read path.

Top module: `clkctl_unit`

## Requirements
- R1: After reset, only the internal oscillator runs. The control register (address 0) reads 0x0000_0005, meaning enable bit 0 and ready bit 2 are set. The switch register (address 1) reads 0. The PLL reference register (address 2) reads 0. `sel_src_o` is 0, `int_rdy_o` is 1, and `ext_rdy_o` and `pll_rdy_o` are 0.
- R2: Each source's run bit sits in the control register: internal at bit 0, external at bit 16, PLL at bit 24. Setting a run bit at clock edge k raises that source's ready flag at edge k+ON_DLY for that source. The flag reads back at bit 2, 17 and 25 respectively, and also appears on its ready output.
- R3: Clearing a run bit at edge k drops that source's ready flag at edge k+OFF_DLY for that source.
- R4: If a run bit returns to the value of its ready flag before the settle delay has elapsed, the flag does not change.
- R5: Ready bits 2, 17 and 25 are read-only. Writing ones to them changes neither the readback nor the ready outputs.
- R6: Control register bits 4:3 hold a 2-bit internal oscillator divider, whose value is the log2 of the division ratio. Bit 18 holds the external oscillator bypass. Both read back as written.
- R7: Switch register bits 2:0 read the active source and bits 5:3 read the requested source. The codes are 0 = internal, 1 = low-power internal, 2 = external, 3 = PLL. A request written at edge k to a ready source becomes active at edge k+1.
- R8: A request to a source that is not ready leaves the active code unchanged. The switch completes one edge after that source's ready flag rises.
- R9: Code 1 (low-power internal) is always treated as ready. A written request code of 4 to 7 is ignored, and the earlier request stays in place.
- R10: Register address 2, bits 1:0, hold the PLL reference select. The codes are 0 = internal, 1 = low-power internal, 2 = external, 3 = none. Only those bits are stored.
- R11: Unmapped addresses read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | DATA_W | Read data for `addr_i` (combinational) |
| sel_src_o | output | 3 | Active system clock source code |
| int_rdy_o | output | 1 | Internal oscillator ready |
| ext_rdy_o | output | 1 | External oscillator ready |
| pll_rdy_o | output | 1 | PLL ready |

## Verification
The bench builds the unit with short, distinct delays:
- internal oscillator: on 3, off 4
- external oscillator: on 5, off 6
- PLL: on 7, off 2

Because every source settles within a few cycles, the exact edge on which each flag changes can be sampled directly, on both sides of it. With an off delay of 4 for the internal oscillator, a run bit can be toggled back inside the settle window to exercise R4. Random enable patterns and switch requests then run through many orderings of pending switches and late-arriving ready flags.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int NUM_OSC = 3;
    localparam int OSC_INT = 0;
    localparam int OSC_EXT = 1;
    localparam int OSC_PLL = 2;

    // System clock source codes
    localparam logic [2:0] SRC_INT = 3'd0;
    localparam logic [2:0] SRC_LPI = 3'd1;
    localparam logic [2:0] SRC_EXT = 3'd2;
    localparam logic [2:0] SRC_PLL = 3'd3;

    // Control register bit positions
    localparam int B_INT_EN   = 0;
    localparam int B_INT_RDY  = 2;
    localparam int B_DIV_LO   = 3;
    localparam int B_EXT_EN   = 16;
    localparam int B_EXT_RDY  = 17;
    localparam int B_EXT_BYP  = 18;
    localparam int B_PLL_EN   = 24;
    localparam int B_PLL_RDY  = 25;

    function automatic logic src_ready(input logic [2:0] code,
                                       input logic [NUM_OSC-1:0] rdy);
        case (code)
            SRC_INT: src_ready = rdy[OSC_INT];
            SRC_LPI: src_ready = 1'b1;
            SRC_EXT: src_ready = rdy[OSC_EXT];
            SRC_PLL: src_ready = rdy[OSC_PLL];
            default: src_ready = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/clkctl_settle.sv
module clkctl_settle #(
    parameter int   ON_DLY  = 4,
    parameter int   OFF_DLY = 4,
    parameter logic RST_RDY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic rdy_o
);
    localparam int MAX_DLY = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
    localparam int CW      = (MAX_DLY > 1) ? $clog2(MAX_DLY + 1) : 1;
    localparam logic [CW-1:0] ON_LIM  = CW'(ON_DLY - 1);
    localparam logic [CW-1:0] OFF_LIM = CW'(OFF_DLY - 1);

    typedef struct packed {
        logic          rdy;
        logic [CW-1:0] cnt;
    } settle_t;

    settle_t st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        st_d = st_q;
        lim  = st_q.rdy ? OFF_LIM : ON_LIM;
        if (en_i == st_q.rdy) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == lim) begin
            st_d.rdy = en_i;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rdy: RST_RDY, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy_o = st_q.rdy;

endmodule

// File: rtl/clkctl_switch.sv
module clkctl_switch
    import clkctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_we_i,
    input  logic [2:0]         req_code_i,
    input  logic [NUM_OSC-1:0] src_rdy_i,
    output logic [2:0]         req_o,
    output logic [2:0]         act_o
);
    typedef struct packed {
        logic [2:0] req;
        logic [2:0] act;
    } sw_t;

    sw_t sw_d, sw_q;

    always_comb begin
        sw_d = sw_q;
        if (req_we_i && (req_code_i <= SRC_PLL)) begin
            sw_d.req = req_code_i;
        end
        if ((sw_q.req != sw_q.act) && src_ready(sw_q.req, src_rdy_i)) begin
            sw_d.act = sw_q.req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q <= '{req: SRC_INT, act: SRC_INT};
        end else begin
            sw_q <= sw_d;
        end
    end

    assign req_o = sw_q.req;
    assign act_o = sw_q.act;

endmodule

// File: rtl/clkctl_unit.sv
module clkctl_unit
    import clkctl_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int CTRL_ADDR   = 0,
    parameter int SWITCH_ADDR = 1,
    parameter int PLLSEL_ADDR = 2,
    parameter int INT_ON_DLY  = 16,
    parameter int INT_OFF_DLY = 8,
    parameter int EXT_ON_DLY  = 2000,
    parameter int EXT_OFF_DLY = 32,
    parameter int PLL_ON_DLY  = 500,
    parameter int PLL_OFF_DLY = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [2:0]        sel_src_o,
    output logic              int_rdy_o,
    output logic              ext_rdy_o,
    output logic              pll_rdy_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_SW   = ADDR_W'(SWITCH_ADDR);
    localparam logic [ADDR_W-1:0] A_PSEL = ADDR_W'(PLLSEL_ADDR);

    typedef struct packed {
        logic       int_en;
        logic [1:0] int_div;
        logic       ext_en;
        logic       ext_byp;
        logic       pll_en;
        logic [1:0] pll_src;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [NUM_OSC-1:0] osc_en;
    logic [NUM_OSC-1:0] osc_rdy;
    logic [2:0]         sw_req;
    logic [2:0]         sw_act;
    logic               sw_we;
    logic               unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        ctl_d = ctl_q;
        if (we_i && (addr_i == A_CTRL)) begin
            ctl_d.int_en  = wdata_i[B_INT_EN];
            ctl_d.int_div = wdata_i[B_DIV_LO +: 2];
            ctl_d.ext_en  = wdata_i[B_EXT_EN];
            ctl_d.ext_byp = wdata_i[B_EXT_BYP];
            ctl_d.pll_en  = wdata_i[B_PLL_EN];
        end
        if (we_i && (addr_i == A_PSEL)) begin
            ctl_d.pll_src = wdata_i[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{int_en: 1'b1, int_div: 2'd0, ext_en: 1'b0,
                       ext_byp: 1'b0, pll_en: 1'b0, pll_src: 2'd0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign osc_en[OSC_INT] = ctl_q.int_en;
    assign osc_en[OSC_EXT] = ctl_q.ext_en;
    assign osc_en[OSC_PLL] = ctl_q.pll_en;

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
        localparam int ON_D  = (g == OSC_INT) ? INT_ON_DLY  :
                               (g == OSC_EXT) ? EXT_ON_DLY  : PLL_ON_DLY;
        localparam int OFF_D = (g == OSC_INT) ? INT_OFF_DLY :
                               (g == OSC_EXT) ? EXT_OFF_DLY : PLL_OFF_DLY;
        localparam logic RST_R = (g == OSC_INT);
        clkctl_settle #(
            .ON_DLY (ON_D),
            .OFF_DLY(OFF_D),
            .RST_RDY(RST_R)
        ) u_settle (
            .clk  (clk),
            .rst_n(rst_n),
            .en_i (osc_en[g]),
            .rdy_o(osc_rdy[g])
        );
    end

    assign sw_we = we_i && (addr_i == A_SW);

    clkctl_switch u_switch (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_we_i  (sw_we),
        .req_code_i(wdata_i[2:0]),
        .src_rdy_i (osc_rdy),
        .req_o     (sw_req),
        .act_o     (sw_act)
    );

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_CTRL) begin
            rdata_o[B_INT_EN]       = ctl_q.int_en;
            rdata_o[B_INT_RDY]      = osc_rdy[OSC_INT];
            rdata_o[B_DIV_LO +: 2]  = ctl_q.int_div;
            rdata_o[B_EXT_EN]       = ctl_q.ext_en;
            rdata_o[B_EXT_RDY]      = osc_rdy[OSC_EXT];
            rdata_o[B_EXT_BYP]      = ctl_q.ext_byp;
            rdata_o[B_PLL_EN]       = ctl_q.pll_en;
            rdata_o[B_PLL_RDY]      = osc_rdy[OSC_PLL];
        end else if (addr_i == A_SW) begin
            rdata_o[2:0] = sw_act;
            rdata_o[5:3] = sw_req;
        end else if (addr_i == A_PSEL) begin
            rdata_o[1:0] = ctl_q.pll_src;
        end
    end

    assign sel_src_o = sw_act;
    assign int_rdy_o = osc_rdy[OSC_INT];
    assign ext_rdy_o = osc_rdy[OSC_EXT];
    assign pll_rdy_o = osc_rdy[OSC_PLL];

endmodule

// File: rtl/clkctl_unit_chk.sv
module clkctl_unit_chk
    import clkctl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_OSC-1:0] osc_en,
    input logic [NUM_OSC-1:0] osc_rdy,
    input logic [2:0]         sel
);
    for (genvar g = 0; g < NUM_OSC; g++) begin : g_chk
        p_rdy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(osc_rdy[g]) |-> $past(osc_en[g]))
            else $error("ready rose without run request");
        p_rdy_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(osc_rdy[g]) |-> !$past(osc_en[g]))
            else $error("ready fell while run request held");
    end

    p_sel_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel <= SRC_PLL)
        else $error("active source code out of range");

    p_sel_to_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != $past(sel)) |-> src_ready(sel, $past(osc_rdy)))
        else $error("switched to a source that was not ready");

endmodule

bind clkctl_unit clkctl_unit_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_en (osc_en),
    .osc_rdy(osc_rdy),
    .sel    (sel_src_o)
);

// File: tb/tb_clkctl_unit.sv
`timescale 1ns/1ps
module tb_clkctl_unit;
    localparam int INT_ON = 3, INT_OFF = 4;
    localparam int EXT_ON = 5, EXT_OFF = 6;
    localparam int PLL_ON = 7, PLL_OFF = 2;
    localparam int SETTLE = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic [2:0]  sel_src;
    logic        int_rdy, ext_rdy, pll_rdy;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clkctl_unit #(
        .INT_ON_DLY(INT_ON), .INT_OFF_DLY(INT_OFF),
        .EXT_ON_DLY(EXT_ON), .EXT_OFF_DLY(EXT_OFF),
        .PLL_ON_DLY(PLL_ON), .PLL_OFF_DLY(PLL_OFF)
    ) dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
        .we_i(we), .rdata_o(rdata), .sel_src_o(sel_src),
        .int_rdy_o(int_rdy), .ext_rdy_o(ext_rdy), .pll_rdy_o(pll_rdy)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic int on_dly(input int s);
        return (s == 0) ? INT_ON : (s == 1) ? EXT_ON : PLL_ON;
    endfunction
    function automatic int off_dly(input int s);
        return (s == 0) ? INT_OFF : (s == 1) ? EXT_OFF : PLL_OFF;
    endfunction
    function automatic logic [31:0] ctrl_word(input logic [2:0] en);
        return {7'd0, en[2], 7'd0, en[1], 15'd0, en[0]};
    endfunction
    function automatic logic code_ready(input logic [2:0] c, input logic [2:0] r);
        return (c == 3'd0) ? r[0] : (c == 3'd1) ? 1'b1 :
               (c == 3'd2) ? r[1] : r[2];
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; we = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [2:0]  en_m, rdy_m, req_m, act_m;
        void'($urandom(32'h00C1_0C4E));
        @(negedge clk);
        do_reset();

        // R1 reset state
        rd(4'd0, v); check("R1 ctrl", v, 32'h0000_0005);
        rd(4'd1, v); check("R1 switch", v, 32'h0);
        rd(4'd2, v); check("R1 pllsel", v, 32'h0);
        check("R1 outputs", {28'd0, sel_src, int_rdy, ext_rdy, pll_rdy},
              {28'd0, 3'd0, 1'b1, 1'b0, 1'b0});

        // R2 external on
        wr(4'd0, 32'h0001_0001);
        tick(EXT_ON - 1); check("R2 ext before", {31'd0, ext_rdy}, 32'd0);
        tick(1);          check("R2 ext at delay", {31'd0, ext_rdy}, 32'd1);
        rd(4'd0, v);      check("R2 ctrl readback", v, 32'h0003_0005);

        // R7 switch to ready source
        wr(4'd1, 32'd2);
        check("R7 not yet", {29'd0, sel_src}, 32'd0);
        tick(1);
        check("R7 switched", {29'd0, sel_src}, 32'd2);
        rd(4'd1, v); check("R7 readback", v, 32'h0000_0012);

        // R8 request to PLL while off
        wr(4'd1, 32'd3);
        tick(3); check("R8 held", {29'd0, sel_src}, 32'd2);
        wr(4'd0, 32'h0101_0001);
        tick(PLL_ON - 1); check("R2 pll before", {31'd0, pll_rdy}, 32'd0);
        tick(1);
        check("R2 pll at delay", {31'd0, pll_rdy}, 32'd1);
        check("R8 still held", {29'd0, sel_src}, 32'd2);
        tick(1); check("R8 completes", {29'd0, sel_src}, 32'd3);

        // R3 external off
        wr(4'd0, 32'h0100_0001);
        tick(EXT_OFF - 1); check("R3 ext before", {31'd0, ext_rdy}, 32'd1);
        tick(1);           check("R3 ext at delay", {31'd0, ext_rdy}, 32'd0);

        // R4 aborted turn-off
        wr(4'd0, 32'h0100_0000);
        tick(1);
        wr(4'd0, 32'h0100_0001);
        tick(INT_OFF + 2); check("R4 int kept", {31'd0, int_rdy}, 32'd1);

        // R5 ready bits read-only
        wr(4'd0, 32'h0302_0005);
        check("R5 ext out", {31'd0, ext_rdy}, 32'd0);
        tick(1);
        check("R5 ext out later", {31'd0, ext_rdy}, 32'd0);
        rd(4'd0, v); check("R5 readback", v, 32'h0300_0005);

        // R6 divider and bypass fields
        wr(4'd0, 32'h0104_0019);
        rd(4'd0, v); check("R6 fields", v, 32'h0304_001D);

        // R9 low-power code and illegal codes
        wr(4'd1, 32'd1);
        check("R9 lpi pending", {29'd0, sel_src}, 32'd3);
        tick(1);
        check("R9 lpi active", {29'd0, sel_src}, 32'd1);
        wr(4'd1, 32'd5);
        tick(2);
        rd(4'd1, v); check("R9 illegal ignored", v, 32'h0000_0009);

        // R10 PLL reference select
        wr(4'd2, 32'd3);
        rd(4'd2, v); check("R10 code3", v, 32'd3);
        wr(4'd2, 32'hFFFF_FFFE);
        rd(4'd2, v); check("R10 masked", v, 32'd2);

        // R11 unmapped address
        wr(4'd7, 32'hFFFF_FFFF);
        rd(4'd7, v); check("R11 reads zero", v, 32'd0);
        rd(4'd0, v); check("R11 ctrl intact", v, 32'h0304_001D);
        rd(4'd1, v); check("R11 switch intact", v, 32'h0000_0009);

        // Random phase
        do_reset();
        en_m = 3'b001; rdy_m = 3'b001; req_m = 3'd0; act_m = 3'd0;
        for (int it = 0; it < 60; it++) begin
            int s;
            logic [2:0] nen;
            logic [2:0] cur;
            s = int'($urandom % 3);
            nen = en_m;
            nen[s] = ~nen[s];
            wr(4'd0, ctrl_word(nen));
            cur = {pll_rdy, ext_rdy, int_rdy};
            if (nen[s]) begin
                tick(on_dly(s) - 1);
                cur = {pll_rdy, ext_rdy, int_rdy};
                check("R2 rand before", {29'd0, cur}, {29'd0, rdy_m});
                tick(1);
                cur = {pll_rdy, ext_rdy, int_rdy};
                check("R2 rand at delay", {31'd0, cur[s]}, 32'd1);
            end else begin
                tick(off_dly(s) - 1);
                cur = {pll_rdy, ext_rdy, int_rdy};
                check("R3 rand before", {29'd0, cur}, {29'd0, rdy_m});
                tick(1);
                cur = {pll_rdy, ext_rdy, int_rdy};
                check("R3 rand at delay", {31'd0, cur[s]}, 32'd0);
            end
            en_m = nen;
            rdy_m = nen;
            tick(SETTLE);
            if (code_ready(req_m, rdy_m)) act_m = req_m;
            check("R8 rand sel", {29'd0, sel_src}, {29'd0, act_m});
            if ($urandom % 2 == 0) begin
                req_m = 3'($urandom % 4);
                wr(4'd1, {29'd0, req_m});
                tick(2);
                if (code_ready(req_m, rdy_m)) act_m = req_m;
                rd(4'd1, v);
                check("R7 rand switch", v, {26'd0, req_m, act_m});
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule